// File: doc/BRIEF.md
# Keyboard Intercept and Key Queue

The block sits between a stream of already-decoded keyboard events and two consumers: the host machine's normal keyboard path and a supervisory program that reaches the block through 8-bit I/O ports. A mode bit written through one port chooses the routing. In normal mode, every event goes straight to the host path, with one exception: presses of the reserved supervisor key (F12, non-extended scan code 0x07) are diverted into a small queue. In intercept mode, every press goes to the queue, no event reaches the host path, and a force-release output tells the host path to report every key as up.

The supervisor reads the scan code at the head of the queue from one port and a status byte from another. Reading the status port removes the head entry. Software therefore reads the code first and then the status, and uses the status to decide whether the code it read was valid. Only presses are ever queued. Whenever the queue holds a key while the block is in normal mode, the block raises a non-maskable interrupt request so that the supervisor can take over.

Top module: `kbd_intercept`

## Requirements
- R1: After reset the queue is empty, the block is in normal mode, `nmi_req_o` and `host_force_up_o` are 0, and both read ports return 0x00.
- R2: In normal mode, every event except an F12 event (code 0x07 with the extended flag clear) appears on the host outputs in the same cycle, with its code, extended and release flags. Such an event is not queued.
- R3: In normal mode, an F12 press is queued and is not forwarded to the host path. An F12 release is neither forwarded nor queued.
- R4: In intercept mode, `host_valid_o` stays 0 for every event, `host_force_up_o` is 1, and every press is queued.
- R5: A release event never enters the queue in either mode.
- R6: A read of port 0x82 returns the scan code at the head of the queue, or 0x00 when the queue is empty. The read does not change the queue.
- R7: A read of port 0x83 returns the status byte. Bit 7 is 1 when a key is waiting. Bit 3 is the ctrl flag, bit 2 the shift flag and bit 0 the extended flag of the head entry, all captured at press time. Bits 1 and 4 to 6 are 0, and the flag bits are 0 when the queue is empty.
- R8: A read of port 0x83 removes the head entry at the end of that cycle. A read of port 0x83 on an empty queue has no effect.
- R9: The queue returns entries in arrival order and holds up to 7 of them. A press that arrives while the queue is full is dropped, and the entries already held are unchanged.
- R10: `nmi_req_o` is 1 exactly when the block is in normal mode and the queue is not empty.
- R11: A write to port 0x81 loads bit 1 of the data as the mode (1 selects intercept). The other data bits, and writes to any other port, leave the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_valid_i | input | 1 | Decoded key event strobe, one cycle per event |
| key_code_i | input | 8 | Scan code of the event |
| key_ext_i | input | 1 | Event carries an extended scan code |
| key_release_i | input | 1 | Event is a release (0 means press) |
| key_shift_i | input | 1 | Shift held at the time of the event |
| key_ctrl_i | input | 1 | Ctrl held at the time of the event |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_addr_i | input | 8 | I/O port number |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, 0x00 unless one of the two read ports is selected |
| host_valid_o | output | 1 | Event forwarded to the host keyboard path |
| host_code_o | output | 8 | Forwarded scan code |
| host_ext_o | output | 1 | Forwarded extended flag |
| host_release_o | output | 1 | Forwarded release flag |
| host_force_up_o | output | 1 | Host path must report all keys released |
| nmi_req_o | output | 1 | Non-maskable interrupt request |

## Verification
Routing is combinational. The host outputs are therefore checked in the same cycle as the event, shortly after the inputs settle and before the next rising edge. A queued press becomes visible on both read ports, and on the interrupt request, right after the rising edge that captures the event. The bench samples these results at the following falling edge. A pop or a mode write takes effect at the edge that ends the access, so every check that follows one of them is made in a later cycle, never during the access itself.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int CODE_W = 8;

  typedef struct packed {
    logic              ext;
    logic              shift;
    logic              ctrl;
    logic [CODE_W-1:0] code;
  } key_ent_t;
endpackage

// File: rtl/kbd_fifo.sv
module kbd_fifo
  import kbd_pkg::*;
#(
  parameter int DEPTH = 7,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  key_ent_t         din_i,
  output key_ent_t         head_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  key_ent_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // full test uses pre-pop count: a push into a full queue is dropped
  assign do_push = push_i && (cnt_q < CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (do_push && (wr_q == PTR_W'(g)))      mem_q[g] <= din_i;
    end
  end

  assign empty_o = (cnt_q == '0);
  assign head_o  = empty_o ? '0 : mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/kbd_route.sv
module kbd_route
  import kbd_pkg::*;
#(
  parameter logic [CODE_W-1:0] SUP_KEY = 8'h07
) (
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ext_i,
  input  logic              release_i,
  input  logic              intercept_i,
  output logic              fwd_o,
  output logic              push_o
);
  logic sup_key;

  assign sup_key = (code_i == SUP_KEY) && !ext_i;
  assign fwd_o   = valid_i && !intercept_i && !sup_key;
  assign push_o  = valid_i && !release_i && (intercept_i || sup_key);
endmodule

// File: rtl/kbd_io.sv
module kbd_io
  import kbd_pkg::*;
#(
  parameter logic [7:0] MODE_PORT = 8'h81,
  parameter logic [7:0] CODE_PORT = 8'h82,
  parameter logic [7:0] STAT_PORT = 8'h83,
  parameter int         MODE_BIT  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  key_ent_t   head_i,
  input  logic       empty_i,
  output logic [7:0] rdata_o,
  output logic       pop_o,
  output logic       intercept_o
);
  logic       mode_q;
  logic       unused_wdata;
  logic [7:0] stat;

  assign unused_wdata = ^(wdata_i & ~(8'(1) << MODE_BIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           mode_q <= 1'b0;
    else if (wr_i && addr_i == MODE_PORT)  mode_q <= wdata_i[MODE_BIT];
  end

  assign stat = {!empty_i, 3'b000, head_i.ctrl, head_i.shift, 1'b0, head_i.ext};

  always_comb begin
    rdata_o = 8'h00;
    if (rd_i && addr_i == CODE_PORT) rdata_o = head_i.code;
    if (rd_i && addr_i == STAT_PORT) rdata_o = stat;
  end

  assign pop_o       = rd_i && (addr_i == STAT_PORT);
  assign intercept_o = mode_q;
endmodule

// File: rtl/kbd_intercept.sv
module kbd_intercept
  import kbd_pkg::*;
#(
  parameter int         DEPTH     = 7,
  parameter logic [7:0] SUP_KEY   = 8'h07,
  parameter logic [7:0] MODE_PORT = 8'h81,
  parameter logic [7:0] CODE_PORT = 8'h82,
  parameter logic [7:0] STAT_PORT = 8'h83,
  localparam int        CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_valid_i,
  input  logic [7:0] key_code_i,
  input  logic       key_ext_i,
  input  logic       key_release_i,
  input  logic       key_shift_i,
  input  logic       key_ctrl_i,
  input  logic       io_wr_i,
  input  logic       io_rd_i,
  input  logic [7:0] io_addr_i,
  input  logic [7:0] io_wdata_i,
  output logic [7:0] io_rdata_o,
  output logic       host_valid_o,
  output logic [7:0] host_code_o,
  output logic       host_ext_o,
  output logic       host_release_o,
  output logic       host_force_up_o,
  output logic       nmi_req_o
);
  logic             intercept, q_push, q_pop, q_empty;
  logic [CNT_W-1:0] q_count;
  key_ent_t         q_head, q_din;

  assign q_din = '{ext: key_ext_i, shift: key_shift_i, ctrl: key_ctrl_i, code: key_code_i};

  kbd_route #(.SUP_KEY(SUP_KEY)) u_route (
    .valid_i    (key_valid_i),
    .code_i     (key_code_i),
    .ext_i      (key_ext_i),
    .release_i  (key_release_i),
    .intercept_i(intercept),
    .fwd_o      (host_valid_o),
    .push_o     (q_push)
  );

  kbd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (q_push),
    .pop_i  (q_pop),
    .din_i  (q_din),
    .head_o (q_head),
    .empty_o(q_empty),
    .count_o(q_count)
  );

  kbd_io #(
    .MODE_PORT(MODE_PORT),
    .CODE_PORT(CODE_PORT),
    .STAT_PORT(STAT_PORT),
    .MODE_BIT (1)
  ) u_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (io_wr_i),
    .rd_i       (io_rd_i),
    .addr_i     (io_addr_i),
    .wdata_i    (io_wdata_i),
    .head_i     (q_head),
    .empty_i    (q_empty),
    .rdata_o    (io_rdata_o),
    .pop_o      (q_pop),
    .intercept_o(intercept)
  );

  assign host_code_o     = key_code_i;
  assign host_ext_o      = key_ext_i;
  assign host_release_o  = key_release_i;
  assign host_force_up_o = intercept;
  assign nmi_req_o       = !intercept && !q_empty;
endmodule

// File: rtl/kbd_intercept_chk.sv
module kbd_intercept_chk #(
  parameter int         DEPTH     = 7,
  parameter logic [7:0] STAT_PORT = 8'h83,
  localparam int        CNT_W     = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             key_valid_i,
  input logic             key_release_i,
  input logic             io_rd_i,
  input logic [7:0]       io_addr_i,
  input logic [7:0]       io_rdata_o,
  input logic             host_valid_o,
  input logic             host_force_up_o,
  input logic             nmi_req_o,
  input logic [CNT_W-1:0] q_count,
  input logic             q_push
);
  logic stat_rd;
  assign stat_rd = io_rd_i && (io_addr_i == STAT_PORT);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CNT_W'(DEPTH)); // R9

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_count == CNT_W'(DEPTH) && !stat_rd) |=> q_count == CNT_W'(DEPTH)); // R9

  AST_NO_RELEASE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && key_release_i) |=> q_count <= $past(q_count)); // R5

  AST_NO_FWD_INTERCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_force_up_o |-> !host_valid_o); // R4

  AST_NMI_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_count != '0 && !host_force_up_o) |-> nmi_req_o); // R10

  AST_NMI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_count == '0 || host_force_up_o) |-> !nmi_req_o); // R10

  AST_STAT_ZERO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |-> (io_rdata_o & 8'h72) == 8'h00); // R7

  AST_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && q_count != '0 && !q_push) |=> q_count == $past(q_count) - CNT_W'(1)); // R8
endmodule

bind kbd_intercept kbd_intercept_chk #(.DEPTH(DEPTH), .STAT_PORT(STAT_PORT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .key_valid_i    (key_valid_i),
  .key_release_i  (key_release_i),
  .io_rd_i        (io_rd_i),
  .io_addr_i      (io_addr_i),
  .io_rdata_o     (io_rdata_o),
  .host_valid_o   (host_valid_o),
  .host_force_up_o(host_force_up_o),
  .nmi_req_o      (nmi_req_o),
  .q_count        (q_count),
  .q_push         (q_push)
);

// File: tb/kbd_intercept_tb.sv
`timescale 1ns/1ps
module kbd_intercept_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kv = 0, kext = 0, krel = 0, ksh = 0, kct = 0;
  logic [7:0] kcode = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata, hcode;
  logic       hvalid, hext, hrel, hforce, nmi;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  kbd_intercept u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .key_valid_i(kv), .key_code_i(kcode), .key_ext_i(kext), .key_release_i(krel),
    .key_shift_i(ksh), .key_ctrl_i(kct),
    .io_wr_i(wr), .io_rd_i(rd), .io_addr_i(addr), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .host_valid_o(hvalid), .host_code_o(hcode), .host_ext_o(hext), .host_release_o(hrel),
    .host_force_up_o(hforce), .nmi_req_o(nmi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one event on a falling edge; routing outputs are checked before the capturing edge
  task automatic key(input logic [7:0] c, input logic e, input logic r, input logic s, input logic t,
                     output logic v, output logic [7:0] oc, output logic oe, output logic orl);
    @(negedge clk);
    kv = 1; kcode = c; kext = e; krel = r; ksh = s; kct = t;
    #1; v = hvalid; oc = hcode; oe = hext; orl = hrel;
    @(negedge clk);
    kv = 0; kext = 0; krel = 0; ksh = 0; kct = 0;
  endtask

  task automatic press(input logic [7:0] c, input logic e, input logic s, input logic t);
    logic v, oe, orl; logic [7:0] oc;
    key(c, e, 1'b0, s, t, v, oc, oe, orl);
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd = 1; addr = a;
    #1; d = rdata;
    @(negedge clk);
    rd = 0; addr = 0;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0; addr = 0; wdata = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 nmi", nmi, 0);
    chk("R1 force_up", hforce, 0);
    chk("R1 host_valid", hvalid, 0);
    io_read(8'h82, d); chk("R1 code port", d, 8'h00);
    io_read(8'h83, d); chk("R1 status port", d, 8'h00);
  endtask

  task automatic t_forward;
    logic v, oe, orl; logic [7:0] oc, d;
    key(8'h1C, 0, 0, 0, 0, v, oc, oe, orl);
    chk("R2 press fwd valid", v, 1); chk("R2 press fwd code", oc, 8'h1C);
    chk("R2 press fwd rel", orl, 0);
    key(8'h1C, 0, 1, 0, 0, v, oc, oe, orl);
    chk("R2 release fwd valid", v, 1); chk("R2 release fwd rel", orl, 1);
    key(8'h07, 1, 0, 0, 0, v, oc, oe, orl);
    chk("R2 ext 0x07 fwd valid", v, 1); chk("R2 ext 0x07 fwd ext", oe, 1);
    io_read(8'h83, d); chk("R2 nothing queued", d, 8'h00);
    chk("R2 no nmi", nmi, 0);
  endtask

  task automatic t_sup_key;
    logic v, oe, orl; logic [7:0] oc, d;
    key(8'h07, 0, 0, 0, 1, v, oc, oe, orl);
    chk("R3 F12 press not fwd", v, 0);
    chk("R10 nmi after F12", nmi, 1);
    io_read(8'h82, d); chk("R6 head code F12", d, 8'h07);
    io_read(8'h82, d); chk("R6 code read keeps head", d, 8'h07);
    io_read(8'h83, d); chk("R7 status F12 ctrl", d, 8'h88);
    chk("R8 pop clears nmi", nmi, 0);
    io_read(8'h83, d); chk("R8 status empty after pop", d, 8'h00);
    io_read(8'h83, d); chk("R8 pop on empty harmless", d, 8'h00);
    key(8'h07, 0, 1, 0, 0, v, oc, oe, orl);
    chk("R3 F12 release not fwd", v, 0);
    io_read(8'h83, d); chk("R5 F12 release not queued", d, 8'h00);
  endtask

  task automatic t_mode;
    io_write(8'h81, 8'hFD); chk("R11 other bits ignored", hforce, 0);
    io_write(8'h80, 8'h02); chk("R11 other port ignored", hforce, 0);
    io_write(8'h81, 8'h02); chk("R11 bit1 sets intercept", hforce, 1);
  endtask

  task automatic t_intercept;
    logic v, oe, orl; logic [7:0] oc, d;
    key(8'h1C, 1, 0, 1, 0, v, oc, oe, orl);
    chk("R4 no fwd in intercept", v, 0);
    chk("R10 no nmi in intercept", nmi, 0);
    key(8'h1B, 0, 1, 0, 0, v, oc, oe, orl);
    chk("R4 release not fwd", v, 0);
    io_read(8'h82, d); chk("R5 head still press code", d, 8'h1C);
    io_read(8'h83, d); chk("R7 status ext+shift", d, 8'h85);
    io_read(8'h83, d); chk("R5 release not queued", d, 8'h00);
  endtask

  task automatic t_fifo;
    logic [7:0] d;
    for (int i = 0; i < 8; i++) press(8'h10 + 8'(i), 0, 0, 1'(i % 2));
    for (int i = 0; i < 7; i++) begin
      io_read(8'h82, d); chk("R9 order code", d, 8'h10 + 8'(i));
      io_read(8'h83, d); chk("R9 order status", d, (i % 2) ? 8'h88 : 8'h80);
    end
    io_read(8'h83, d); chk("R9 overflow press dropped", d, 8'h00);
  endtask

  task automatic t_nmi_leave;
    logic [7:0] d;
    press(8'h2A, 0, 0, 0);
    chk("R10 nmi held off in intercept", nmi, 0);
    io_write(8'h81, 8'h00);
    chk("R10 nmi on leaving intercept", nmi, 1);
    chk("R11 cleared mode", hforce, 0);
    io_read(8'h83, d); chk("R7 status plain", d, 8'h80);
    chk("R10 nmi drops when empty", nmi, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_sup_key();
    t_mode();
    t_intercept();
    t_fifo();
    t_nmi_leave();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule